// File: doc/BRIEF.md
# Connection Memory Block-Fill Engine

This block loads one value into every location of a chosen on-chip connection memory after a single write to a mode register. Software first picks the target memory by writing a separate select register. It then writes the mode register with the start bit set and a 4-bit fill value in the same write. From that write on, the engine generates the address, data and write enable for the target memory on its own. It writes one location per clock, starting at address 0 and counting upward.

Every word written carries the 4-bit fill value in its upper nibble and zero in its lower nibble. When the last location has been written, the start bit clears itself, so software polls the bit to confirm completion. Writing the start bit low during a fill stops the fill at once.

Two polarity bits share the mode register. They always take the value of the most recent write. A start request is refused while the device-initialization function is active. Ordinary CPU writes to the memories are dropped while a fill runs. The memories are modelled as plain arrays with an asynchronous read port so that their contents can be inspected.

Top module: `blockfill_engine`

## Requirements
- R1: After reset the mode register reads 0x00 (start bit 0, polarity bits 0, fill value 0) and no fill is running.
- R2: A mode-register write with bit 0 set, taken while no fill runs and `initBusy` is low, starts a fill. Bit 0 reads 1 from the next cycle.
- R3: A fill writes `{fill value, 4'b0000}` into every location of the selected memory, where the fill value is bits 7:4 of the starting write. The other memory is left unchanged.
- R4: A fill writes one location per clock in ascending order from address 0. Bit 0 reads 1 for exactly 256 cycles and then returns to 0 by itself.
- R5: A mode-register write with bit 0 clear, taken during a fill, stops the fill from that clock edge. No further location is written, and bit 0 reads 0 in the next cycle.
- R6: Bits 1 and 2 of the mode register (parallel and serial frame-pulse polarity) and bits 7:4 (fill value) read back as last written, on every write, whatever the value of bit 0. Bit 3 reads 0.
- R7: A start request taken while `initBusy` is high is ignored. Bit 0 reads 0 and no memory location changes.
- R8: CPU memory writes (`cpuWrEn`) taken while a fill runs are dropped. When no fill runs, they store `cpuWrData` at `cpuWrAddr` of memory `cpuWrSel`.
- R9: The target memory and the fill value are fixed when the fill starts. Select-register writes and mode writes with bit 0 set during a fill do not redirect, alter or restart it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| initBusy | input | 1 | Device initialization in progress |
| cfgWrEn | input | 1 | Mode register write strobe |
| cfgWrData | input | 8 | Mode register write data: bit 0 start, bits 2:1 polarity, bits 7:4 fill value |
| cfgRdData | output | 8 | Mode register readback |
| selWrEn | input | 1 | Select register write strobe |
| selWrData | input | 1 | Target memory number |
| cpuWrEn | input | 1 | Normal CPU memory write strobe |
| cpuWrSel | input | 1 | Memory number for the CPU write |
| cpuWrAddr | input | 8 | Address for the CPU write |
| cpuWrData | input | 8 | Data for the CPU write |
| rdSel | input | 1 | Memory number for the inspection read |
| rdAddr | input | 8 | Address for the inspection read |
| rdData | output | 8 | Asynchronous read data |

## Verification
A wrong busy flag shows in bit 0 of the mode readback in the very next cycle. It also shows as a fill that lasts other than 256 cycles, as CPU writes that are dropped or accepted wrongly, or as a start that is not refused during initialization. A wrong address counter, latched fill word or latched target shows only in memory contents. It therefore appears when the memories are swept after a fill or an abort. An abort that takes effect one edge late leaves one extra written location behind.

// File: rtl/blockfill_pkg.sv
package blockfill_pkg;
  // strobes from the control to the datapath
  typedef struct packed {
    logic start;  // load counter, latch fill word and target
    logic write;  // write current location and advance
    logic halt;   // fill ends at this edge
  } fillCmd_t;

  localparam int GO_BIT   = 0;
  localparam int PPOL_BIT = 1;
  localparam int SPOL_BIT = 2;
  localparam int NIB_LSB  = 4;
  localparam int NIB_W    = 4;
endpackage

// File: rtl/blockfill_ctrl.sv
module blockfill_ctrl
  import blockfill_pkg::*;
#(
  parameter int SEL_W = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             initBusy,
  input  logic             cfgWrEn,
  input  logic [7:0]       cfgWrData,
  input  logic             selWrEn,
  input  logic [SEL_W-1:0] selWrData,
  input  logic             lastAddr,
  output fillCmd_t         cmd,
  output logic             fillBusy,
  output logic [NIB_W-1:0] startNib,
  output logic [SEL_W-1:0] startSel,
  output logic [7:0]       cfgRdData
);
  logic             busy;
  logic [1:0]       polBits;
  logic [NIB_W-1:0] nibReg;
  logic [SEL_W-1:0] selReg;
  logic             goReq, haltReq;

  assign goReq   = cfgWrEn & cfgWrData[GO_BIT];
  assign haltReq = cfgWrEn & ~cfgWrData[GO_BIT];

  always_comb begin
    cmd.start = goReq & ~busy & ~initBusy;
    cmd.write = busy & ~haltReq;
    cmd.halt  = busy & (haltReq | lastAddr);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      polBits <= '0;
      nibReg  <= '0;
      selReg  <= '0;
    end else begin
      if (cmd.start)     busy <= 1'b1;
      else if (cmd.halt) busy <= 1'b0;
      if (cfgWrEn) begin
        polBits <= {cfgWrData[SPOL_BIT], cfgWrData[PPOL_BIT]};
        nibReg  <= cfgWrData[NIB_LSB +: NIB_W];
      end
      if (selWrEn) selReg <= selWrData;
    end
  end

  assign fillBusy  = busy;
  assign startNib  = cfgWrData[NIB_LSB +: NIB_W];
  assign startSel  = selReg;
  assign cfgRdData = {nibReg, 1'b0, polBits, busy};
endmodule

// File: rtl/blockfill_datapath.sv
module blockfill_datapath
  import blockfill_pkg::*;
#(
  parameter int DEPTH    = 256,
  parameter int DATA_W   = 8,
  parameter int NUM_MEMS = 2,
  parameter int SEL_W    = 1,
  parameter int ADDR_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  fillCmd_t          cmd,
  input  logic [NIB_W-1:0]  startNib,
  input  logic [SEL_W-1:0]  startSel,
  input  logic              fillBusy,
  input  logic              cpuWrEn,
  input  logic [SEL_W-1:0]  cpuWrSel,
  input  logic [ADDR_W-1:0] cpuWrAddr,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic [SEL_W-1:0]  rdSel,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic              lastAddr,
  output logic [ADDR_W-1:0] fillAddr,
  output logic [DATA_W-1:0] rdData
);
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

  logic [DATA_W-1:0] fillWord;
  logic [SEL_W-1:0]  tgt;
  logic              cpuGo;
  logic [DATA_W-1:0] bankRd [NUM_MEMS];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      fillAddr <= '0;
      fillWord <= '0;
      tgt      <= '0;
    end else if (cmd.start) begin
      fillAddr <= '0;
      fillWord <= {startNib, {(DATA_W-NIB_W){1'b0}}};
      tgt      <= startSel;
    end else if (cmd.write) begin
      fillAddr <= fillAddr + ADDR_W'(1);
    end
  end

  assign lastAddr = (fillAddr == LAST);
  assign cpuGo    = cpuWrEn & ~fillBusy;

  for (genvar m = 0; m < NUM_MEMS; m++) begin : g_bank
    logic [DATA_W-1:0] store [DEPTH];
    logic              fillHit, cpuHit;
    assign fillHit = cmd.write & (tgt == SEL_W'(m));
    assign cpuHit  = cpuGo & (cpuWrSel == SEL_W'(m));
    always_ff @(posedge clk) begin
      if (fillHit)     store[fillAddr]  <= fillWord;
      else if (cpuHit) store[cpuWrAddr] <= cpuWrData;
    end
    assign bankRd[m] = store[rdAddr];
  end

  assign rdData = bankRd[rdSel];
endmodule

// File: rtl/blockfill_engine.sv
module blockfill_engine
  import blockfill_pkg::*;
#(
  parameter int DEPTH    = 256,
  parameter int DATA_W   = 8,
  parameter int NUM_MEMS = 2,
  localparam int SEL_W   = (NUM_MEMS > 1) ? $clog2(NUM_MEMS) : 1,
  localparam int ADDR_W  = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              initBusy,
  input  logic              cfgWrEn,
  input  logic [7:0]        cfgWrData,
  output logic [7:0]        cfgRdData,
  input  logic              selWrEn,
  input  logic [SEL_W-1:0]  selWrData,
  input  logic              cpuWrEn,
  input  logic [SEL_W-1:0]  cpuWrSel,
  input  logic [ADDR_W-1:0] cpuWrAddr,
  input  logic [DATA_W-1:0] cpuWrData,
  input  logic [SEL_W-1:0]  rdSel,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);
  fillCmd_t          cmd;
  logic              fillBusy, lastAddr;
  logic [NIB_W-1:0]  startNib;
  logic [SEL_W-1:0]  startSel;
  logic [ADDR_W-1:0] fillAddr;

  blockfill_ctrl #(.SEL_W(SEL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .initBusy(initBusy),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .selWrEn(selWrEn), .selWrData(selWrData),
    .lastAddr(lastAddr), .cmd(cmd), .fillBusy(fillBusy),
    .startNib(startNib), .startSel(startSel), .cfgRdData(cfgRdData)
  );

  blockfill_datapath #(
    .DEPTH(DEPTH), .DATA_W(DATA_W), .NUM_MEMS(NUM_MEMS),
    .SEL_W(SEL_W), .ADDR_W(ADDR_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .startNib(startNib),
    .startSel(startSel), .fillBusy(fillBusy),
    .cpuWrEn(cpuWrEn), .cpuWrSel(cpuWrSel), .cpuWrAddr(cpuWrAddr),
    .cpuWrData(cpuWrData), .rdSel(rdSel), .rdAddr(rdAddr),
    .lastAddr(lastAddr), .fillAddr(fillAddr), .rdData(rdData)
  );
endmodule

// File: rtl/blockfill_checker.sv
module blockfill_checker #(
  parameter int DEPTH  = 256,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              initBusy,
  input logic              cfgWrEn,
  input logic [7:0]        cfgWrData,
  input logic [7:0]        cfgRdData,
  input logic              fillBusy,
  input logic [ADDR_W-1:0] fillAddr
);
  a_r2_start_at_zero: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fillBusy) |-> fillAddr == '0);

  a_r2_go_reads_one: assert property (@(posedge clk) disable iff (!rstN)
    $past(cfgWrEn && cfgWrData[0] && !fillBusy && !initBusy) |-> cfgRdData[0]);

  a_r4_addr_steps: assert property (@(posedge clk) disable iff (!rstN)
    (fillBusy && $past(fillBusy)) |-> fillAddr == $past(fillAddr) + ADDR_W'(1));

  a_r4_ends_after_last: assert property (@(posedge clk) disable iff (!rstN)
    (fillBusy && fillAddr == ADDR_W'(DEPTH - 1)) |=> !fillBusy);

  a_r5_abort_stops: assert property (@(posedge clk) disable iff (!rstN)
    (fillBusy && cfgWrEn && !cfgWrData[0]) |=> !fillBusy);

  a_r6_pol_follows_write: assert property (@(posedge clk) disable iff (!rstN)
    $past(cfgWrEn) |-> cfgRdData[2:1] == $past(cfgWrData[2:1]));

  a_r7_init_blocks_start: assert property (@(posedge clk) disable iff (!rstN)
    (!fillBusy && initBusy) |=> !fillBusy);
endmodule

bind blockfill_engine blockfill_checker #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .initBusy(initBusy), .cfgWrEn(cfgWrEn),
  .cfgWrData(cfgWrData), .cfgRdData(cfgRdData),
  .fillBusy(fillBusy), .fillAddr(fillAddr)
);

// File: tb/tb_blockfill_engine.sv
`timescale 1ns/1ps
module tb_blockfill_engine;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       initBusy = 1'b0;
  logic       cfgWrEn = 1'b0;
  logic [7:0] cfgWrData = '0;
  logic [7:0] cfgRdData;
  logic       selWrEn = 1'b0;
  logic       selWrData = 1'b0;
  logic       cpuWrEn = 1'b0;
  logic       cpuWrSel = 1'b0;
  logic [7:0] cpuWrAddr = '0;
  logic [7:0] cpuWrData = '0;
  logic       rdSel = 1'b0;
  logic [7:0] rdAddr = '0;
  logic [7:0] rdData;

  int tests = 0;
  int fails = 0;
  string curReq = "R1";

  // behavioural reference state
  logic [7:0] refMem [2][256];
  bit         refBusy = 0;
  int         refAddr = 0;
  logic [7:0] refWord = '0;
  int         refTgt = 0;
  int         refSel = 0;
  logic [1:0] refPol = '0;
  logic [3:0] refNib = '0;

  always #2 clk = ~clk;

  blockfill_engine dut (
    .clk(clk), .rstN(rstN), .initBusy(initBusy), .cfgWrEn(cfgWrEn),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .selWrEn(selWrEn),
    .selWrData(selWrData), .cpuWrEn(cpuWrEn), .cpuWrSel(cpuWrSel),
    .cpuWrAddr(cpuWrAddr), .cpuWrData(cpuWrData), .rdSel(rdSel),
    .rdAddr(rdAddr), .rdData(rdData)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] expRd();
    return {refNib, 1'b0, refPol, refBusy};
  endfunction

  task automatic modelEdge();
    bit abort;
    bit startNow;
    if (!rstN) begin
      refBusy = 0; refAddr = 0; refPol = '0; refNib = '0; refSel = 0;
      return;
    end
    abort = cfgWrEn && !cfgWrData[0];
    startNow = !refBusy && cfgWrEn && cfgWrData[0] && !initBusy;
    if (refBusy && !abort) refMem[refTgt][refAddr] = refWord;
    if (cpuWrEn && !refBusy) refMem[cpuWrSel][cpuWrAddr] = cpuWrData;
    if (refBusy) begin
      if (abort || refAddr == 255) refBusy = 0;
      else refAddr++;
    end else if (startNow) begin
      refBusy = 1; refAddr = 0;
      refWord = {cfgWrData[7:4], 4'h0};
      refTgt = refSel;
    end
    if (cfgWrEn) begin
      refPol = cfgWrData[2:1];
      refNib = cfgWrData[7:4];
    end
    if (selWrEn) refSel = selWrData;
  endtask

  // one clock: model follows the edge, readback compared at the falling edge
  task automatic step();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    check(curReq, 32'(cfgRdData), 32'(expRd()));
  endtask

  task automatic cfgWrite(input logic [7:0] d);
    cfgWrEn = 1'b1; cfgWrData = d;
    step();
    cfgWrEn = 1'b0;
  endtask

  task automatic checkMem(input string req);
    int bad = 0;
    for (int m = 0; m < 2; m++) begin
      for (int a = 0; a < 256; a++) begin
        rdSel = m[0]; rdAddr = a[7:0];
        #0.001;
        if (rdData !== refMem[m][a]) begin
          if (bad == 0)
            $display("FAIL %s: mem%0d[%0d] actual %0h expected %0h",
                     req, m, a, rdData, refMem[m][a]);
          bad++;
        end
      end
    end
    tests++;
    if (bad != 0) fails++;
    @(negedge clk);
  endtask

  task automatic runIdle(output int busyCycles);
    busyCycles = 0;
    for (int i = 0; i < 400 && refBusy; i++) begin
      step();
      if (cfgRdData[0]) busyCycles++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R4: watchdog actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n;
    // R1: reset state
    curReq = "R1";
    step(); step();
    check("R1", 32'(cfgRdData), 32'h00);
    rstN = 1'b1;
    step();
    check("R1", 32'(cfgRdData), 32'h00);

    // R8: idle CPU writes land; preload both memories
    curReq = "R8";
    for (int m = 0; m < 2; m++) begin
      for (int a = 0; a < 256; a++) begin
        cpuWrEn = 1'b1; cpuWrSel = m[0]; cpuWrAddr = a[7:0];
        cpuWrData = a[7:0] ^ (m == 1 ? 8'hA5 : 8'h3C);
        step();
      end
    end
    cpuWrEn = 1'b0;
    checkMem("R8");

    // R2/R3/R4: fill memory 0 with nibble B, parallel polarity set
    curReq = "R2";
    selWrEn = 1'b1; selWrData = 1'b0; step(); selWrEn = 1'b0;
    cfgWrite(8'hB3);
    check("R2", 32'(cfgRdData[0]), 32'd1);
    curReq = "R4";
    runIdle(n);
    check("R4", 32'(n + 1), 32'd256);
    check("R4", 32'(cfgRdData), 32'hB2);
    checkMem("R3");

    // R9/R8/R6: fill memory 1 with nibble 6, disturb it on the way
    curReq = "R9";
    selWrEn = 1'b1; selWrData = 1'b1; step(); selWrEn = 1'b0;
    cfgWrite(8'h65);
    repeat (5) step();
    cpuWrEn = 1'b1; cpuWrSel = 1'b1; cpuWrAddr = 8'd200; cpuWrData = 8'h11; step();
    cpuWrSel = 1'b0; cpuWrAddr = 8'd5; cpuWrData = 8'h22; step();
    cpuWrEn = 1'b0;
    selWrEn = 1'b1; selWrData = 1'b0; step(); selWrEn = 1'b0;
    cfgWrite(8'hF3);
    check("R6", 32'(cfgRdData), 32'hF3);
    runIdle(n);
    check("R9", 32'(cfgRdData), 32'hF2);
    checkMem("R9");

    // R7: start refused during initialization
    curReq = "R7";
    selWrEn = 1'b1; selWrData = 1'b1; step(); selWrEn = 1'b0;
    initBusy = 1'b1;
    cfgWrite(8'h71);
    check("R7", 32'(cfgRdData), 32'h70);
    repeat (4) step();
    initBusy = 1'b0;
    step();
    check("R7", 32'(cfgRdData[0]), 32'd0);
    checkMem("R7");

    // R5: abort part-way through a fill of memory 1
    curReq = "R5";
    cfgWrite(8'h91);
    repeat (40) step();
    cfgWrite(8'h90);
    check("R5", 32'(cfgRdData), 32'h90);
    repeat (3) step();
    checkMem("R5");

    // R6: polarity-only write, start bit clear while idle
    curReq = "R6";
    cfgWrite(8'h06);
    check("R6", 32'(cfgRdData), 32'h06);
    cfgWrite(8'h52);
    check("R6", 32'(cfgRdData), 32'h52);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule